// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block exposes a bank of byte-wide configuration registers to a host through a single 32-bit control word. The host does not map the registers one by one. It writes one word that carries several fields: a register index, a byte to store, a store strobe and an active-low hold for the whole bank. The low byte of the same word, when read, shows the register that the index currently selects.

A read is one host write that sets a new index with the strobe low, followed by a read of the word. The selected byte appears as soon as the write lands. A store has three steps. The host first writes the index and the byte with the strobe low. It then writes the same word with the strobe high, and finally writes it again with the strobe low. The bank records the byte once, on the rising edge of the strobe.

The bank holds 25 registers by default, so indices 25 to 31 of the 5-bit index space are empty. While the bank-hold bit is low, all registers are cleared and the bank accepts no stores. A system reset clears the control word, which leaves the bank held.

Top module: `regwin_bridge`

## Requirements
- R1: A host write stores bit 28 (bank run, active high), bit 24 (store strobe), bits 20:16 (register index) and bits 15:8 (store byte) of the control word. From the next clock cycle on, these four fields read back at the same positions.
- R2: Bits 7:0 of the read word always show the register selected by the current index field. The new selection is visible in the first cycle after the write that changes the index, with no further handshake.
- R3: A 0-to-1 change of the strobe field stores the store byte into the indexed register. The change is detected one clock cycle after the host write that set the strobe, so the stored value reads back in the second cycle after that write.
- R4: Keeping the strobe at 1 across further host writes, or clearing it, stores nothing. A register keeps its value when the strobe is rewritten high with different data.
- R5: Indices 25 to 31 hold no register. A store to one of them changes no register, and a read of one of them returns 0x00 in bits 7:0.
- R6: While bit 28 is 0, every register reads 0x00 and strobe edges store nothing. When bit 28 returns to 1, the registers read 0x00 until a new value is stored.
- R7: After system reset the whole read word is 0x00000000, so the bank is held.
- R8: Bits 31:29, 27:25 and 23:21 always read 0. Writes to bits 7:0 have no effect on the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, synchronous |
| host_we | input | 1 | Host write enable for the control word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Control word as read by the host, with the selected register in bits 7:0 |

## Verification
The bench builds the block with its default parameters: a 5-bit index and 25 registers. With these values the indices 25 to 31 exist in the index field but hold no register, so the bench can check the empty part of the address space (R5). The top index, 24, is reached by a real store. Per-cycle sampling makes the timing visible: the new selection shows in the first cycle after an index write, and a store shows only in the second cycle after the strobe write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int WORD_W    = 32;
    localparam int IDX_W     = 5;
    localparam int BYTE_W    = 8;

    // Field positions inside the host control word.
    localparam int RBYTE_LSB = 0;
    localparam int WBYTE_LSB = 8;
    localparam int IDX_LSB   = 16;
    localparam int STB_POS   = 24;
    localparam int RUN_POS   = 28;

    typedef struct packed {
        logic              run;
        logic              stb;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] wbyte;
    } ctrl_word_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output ctrl_word_t        ctrl,
    output logic              store
);

    typedef struct packed {
        ctrl_word_t word;
        logic       stb_prev;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    // Bits of the host word that hold no field.
    logic unused_wbits;
    assign unused_wbits = ^{host_wdata[31:29], host_wdata[27:25],
                            host_wdata[23:21], host_wdata[7:0]};

    always_comb begin
        state_d          = state_q;
        state_d.stb_prev = state_q.word.stb;
        if (host_we) begin
            state_d.word.run   = host_wdata[RUN_POS];
            state_d.word.stb   = host_wdata[STB_POS];
            state_d.word.idx   = host_wdata[IDX_LSB +: IDX_W];
            state_d.word.wbyte = host_wdata[WBYTE_LSB +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl  = state_q.word;
    // Store on a rising strobe only while the bank runs.
    assign store = state_q.word.stb & ~state_q.stb_prev & state_q.word.run;

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int NUM_REGS = 25,
    parameter int IDX_W    = 5,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              store,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [IDX_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rbyte
);

    localparam int IDX_SPAN = 1 << IDX_W;

    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    generate
        if (NUM_REGS > IDX_SPAN) begin : g_bad_size
            initial $error("NUM_REGS exceeds index span");
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!run) begin
                regs_d[i] = '0;
            end else if (store && (widx == i[IDX_W-1:0])) begin
                regs_d[i] = wbyte;
            end else begin
                regs_d[i] = regs_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // Empty indices fall through to zero.
    always_comb begin
        rbyte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (run && (ridx == i[IDX_W-1:0])) begin
                rbyte = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int NUM_REGS = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    ctrl_word_t        ctrl;
    logic              store;
    logic [BYTE_W-1:0] rbyte;

    regwin_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .ctrl       (ctrl),
        .store      (store)
    );

    regwin_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .BYTE_W   (BYTE_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .store (store),
        .widx  (ctrl.idx),
        .wbyte (ctrl.wbyte),
        .ridx  (ctrl.idx),
        .rbyte (rbyte)
    );

    always_comb begin
        host_rdata                         = '0;
        host_rdata[RUN_POS]                = ctrl.run;
        host_rdata[STB_POS]                = ctrl.stb;
        host_rdata[IDX_LSB +: IDX_W]       = ctrl.idx;
        host_rdata[WBYTE_LSB +: BYTE_W]    = ctrl.wbyte;
        host_rdata[RBYTE_LSB +: BYTE_W]    = rbyte;
    end

endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
    parameter int NUM_REGS = 25
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata
);

    // R1: the host-writable fields read back one cycle after a write.
    p_fields_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (host_rdata[28] == $past(host_wdata[28])) &&
                    (host_rdata[24] == $past(host_wdata[24])) &&
                    (host_rdata[20:8] == $past(host_wdata[20:8])));

    // R3: a rising strobe on a running, valid index lands the byte.
    p_store_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_rdata[24]) && host_rdata[28] && !host_we &&
         (int'(host_rdata[20:16]) < NUM_REGS))
        |=> host_rdata[7:0] == $past(host_rdata[15:8]));

    // R4: a strobe held high with no host write leaves the byte alone.
    p_held_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[24] && $past(host_rdata[24]) && !host_we)
        |=> $stable(host_rdata[7:0]));

    // R5: empty indices read zero.
    p_empty_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(host_rdata[20:16]) >= NUM_REGS) |-> host_rdata[7:0] == 8'h00);

    // R6: a held bank reads zero.
    p_held_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[28] |-> host_rdata[7:0] == 8'h00);

    // R8: reserved bits stay clear.
    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[31:29] == 3'b0) && (host_rdata[27:25] == 3'b0) &&
        (host_rdata[23:21] == 3'b0));

endmodule

bind regwin_bridge regwin_bridge_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 19;

    typedef struct packed {
        logic [31:0] wword;
        logic [31:0] expect_w;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [31:0] mk(input logic run, input logic stb,
                                       input logic [4:0] idx,
                                       input logic [7:0] wb,
                                       input logic [7:0] rb);
        return {3'b0, run, 3'b0, stb, 3'b0, idx, wb, rb};
    endfunction

    // Each entry: host write, then the word two cycles later.
    localparam vec_t VECS [NVEC] = '{
        '{mk(1,0,3,8'h00,8'h00), mk(1,0,3,8'h00,8'h00), 4'd2},  // R2 empty reg3
        '{mk(1,0,3,8'hA5,8'h00), mk(1,0,3,8'hA5,8'h00), 4'd1},  // R1 fields
        '{mk(1,1,3,8'hA5,8'h00), mk(1,1,3,8'hA5,8'hA5), 4'd3},  // R3 store
        '{mk(1,0,3,8'hA5,8'h00), mk(1,0,3,8'hA5,8'hA5), 4'd4},  // R4 falling
        '{mk(1,0,7,8'h3C,8'h00), mk(1,0,7,8'h3C,8'h00), 4'd2},  // R2
        '{mk(1,1,7,8'h3C,8'h00), mk(1,1,7,8'h3C,8'h3C), 4'd3},  // R3
        '{mk(1,1,7,8'h99,8'h00), mk(1,1,7,8'h99,8'h3C), 4'd4},  // R4 held high
        '{mk(1,0,3,8'h99,8'h00), mk(1,0,3,8'h99,8'hA5), 4'd2},  // R2
        '{mk(1,0,24,8'h5A,8'h00), mk(1,0,24,8'h5A,8'h00), 4'd2},
        '{mk(1,1,24,8'h5A,8'h00), mk(1,1,24,8'h5A,8'h5A), 4'd3}, // R3 top index
        '{mk(1,0,25,8'h77,8'h00), mk(1,0,25,8'h77,8'h00), 4'd5},
        '{mk(1,1,25,8'h77,8'h00), mk(1,1,25,8'h77,8'h00), 4'd5}, // R5
        '{mk(1,0,31,8'h00,8'h00), mk(1,0,31,8'h00,8'h00), 4'd5},
        '{32'hFFFF_FFFF,          32'h111F_FF00,          4'd8}, // R8
        '{mk(1,0,0,8'h00,8'h00), mk(1,0,0,8'h00,8'h00), 4'd5},  // R5 reg0 untouched
        '{mk(0,0,3,8'h00,8'h00), mk(0,0,3,8'h00,8'h00), 4'd6},  // R6 held
        '{mk(0,1,3,8'h11,8'h00), mk(0,1,3,8'h11,8'h00), 4'd6},  // R6 edge ignored
        '{mk(1,0,3,8'h00,8'h00), mk(1,0,3,8'h00,8'h00), 4'd6},  // R6 cleared
        '{mk(1,0,7,8'h00,8'h00), mk(1,0,7,8'h00,8'h00), 4'd6}   // R6 cleared
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    regwin_bridge i_regwin_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] exp_w);
        n_checks++;
        if (host_rdata !== exp_w) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, host_rdata, exp_w);
        end
    endtask

    // Drive a word; return at the first negedge after it lands.
    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we    = 1'b0;
        host_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R7 reset word", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            host_write(VECS[k].wword);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].expect_w);
        end

        // R3 timing: byte absent one cycle after the strobe write, present after two.
        host_write(mk(1,0,2,8'hC3,8'h00));
        host_write(mk(1,1,2,8'hC3,8'h00));
        check("R3 not yet stored", mk(1,1,2,8'hC3,8'h00));
        @(negedge clk);
        check("R3 stored", mk(1,1,2,8'hC3,8'hC3));
        host_write(mk(1,1,2,8'hC3,8'h00));
        @(negedge clk);
        check("R4 rewrite high", mk(1,1,2,8'hC3,8'hC3));

        // R2: new selection visible in the first cycle.
        host_write(mk(1,0,9,8'h00,8'h00));
        check("R2 switch to empty reg", mk(1,0,9,8'h00,8'h00));
        host_write(mk(1,0,2,8'h00,8'h00));
        check("R2 switch back", mk(1,0,2,8'h00,8'hC3));

        // R7: system reset mid-run clears the word and the bank.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset mid-run", 32'h0);
        rst_n = 1'b1;
        host_write(mk(1,0,2,8'h00,8'h00));
        check("R7 bank cleared", mk(1,0,2,8'h00,8'h00));

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule